// File: doc/BRIEF.md
# Sixteen-Pin I/O Port with Peripheral Function Select

This block controls a parameterised group of pins, sixteen by default, for a larger chip. A pin works either as a general-purpose input/output under software control or is lent to one of several on-chip peripherals, four by default. Software reaches the port through a simple register bus. The bus has a write strobe, a 3-bit address, write data, and read data that is valid in the same cycle as the address.

In general-purpose mode, an output latch and a direction register drive each pad. Both can be rewritten whole or changed bit by bit through set and clear addresses. Pad inputs pass through a synchronizer. They can be read back only where the pin's input-enable bit is on. In peripheral mode, the pad's output value and output enable come from the selected peripheral's vectors. The synchronized pad input is routed to that one peripheral only. All configuration can be read back, so it can be saved and later restored.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset, every register holds zero, every pad is undriven with pad_oe = 0 and pad_out = 0, and every bus address reads zero.
- R2: A write to address 0 replaces the whole output latch with wdata[15:0]. Reading address 1 or address 2 returns the latch.
- R3: A write to address 1 sets the latch bits whose mask bit is 1. A write to address 2 clears them. Bits written with 0 keep their value.
- R4: A write to address 3 sets direction bits, and a write to address 4 clears them. Reading either address returns the direction register. For a pin in general-purpose mode, pad_oe equals its direction bit (1 = output) and pad_out equals its latch bit.
- R5: Setting a direction bit through address 3 clears that pin's input-enable bit. Clearing a direction bit through address 4 sets that pin's input-enable bit.
- R6: Address 5 is the input-enable register, readable and writable as a whole. A pin whose input-enable bit is 0 contributes 0 to the pin-state read unless it is a general-purpose output.
- R7: Reading address 0 returns the pin state, one bit per pin. A general-purpose output returns its latch bit. Every other pin returns its synchronized pad input ANDed with its input-enable bit.
- R8: A pad input change becomes visible to reads and to peripherals after two rising clock edges.
- R9: Address 6 holds the function-enable bits, where 1 lends the pin to a peripheral. Address 7 holds the function selectors, with pin n using bits 2n+1:2n. For a lent pin, pad_out and pad_oe come from fn_out and fn_oe at bit f*16+n, where f is the selected function. The pin's direction bit then has no effect on its pad.
- R10: fn_in bit f*16+n carries pin n's synchronized input only when the pin is lent to function f. All other fn_in bits are 0.
- R11: Registers at addresses 5, 6 and 7 read back the value last written. The upper read bits of 16-bit registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_out | output | 16 | Value driven onto each pad |
| pad_oe | output | 16 | Output enable for each pad |
| pad_in | input | 16 | Raw pad input values |
| fn_out | input | 64 | Peripheral output values, function f at bits f*16+15:f*16 |
| fn_oe | input | 64 | Peripheral output enables, same layout as fn_out |
| fn_in | output | 64 | Synchronized inputs routed to peripherals, same layout |

## Verification
The two activities that can land in the same cycle are a pad input emerging from the synchronizer and a bus write that reconfigures the same pin. The write may change its input enable, direction or function ownership. A long random phase drives writes to every address together with fresh pad and peripheral vectors on every clock, so these events coincide often. A behavioural reference model, updated at each rising edge, predicts read data, pad drive and peripheral inputs for each cycle. The bench compares these against the outputs between edges, so each collision is judged by whether the read and the routing agree with the configuration in force at that edge.

// File: rtl/gpm_pkg.sv
package gpm_pkg;

   typedef enum logic [2:0] {
      GPM_PIN_DATA = 3'd0,
      GPM_OUT_SET  = 3'd1,
      GPM_OUT_CLR  = 3'd2,
      GPM_DIR_SET  = 3'd3,
      GPM_DIR_CLR  = 3'd4,
      GPM_IN_EN    = 3'd5,
      GPM_FN_EN    = 3'd6,
      GPM_FN_SEL   = 3'd7
   } gpm_addr_e;

   localparam int GPM_ADDR_W = 3;

endpackage

// File: rtl/gpm_sync.sv
module gpm_sync #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpm_regs.sv
module gpm_regs
   import gpm_pkg::*;
#(
   parameter int PINS     = 16,
   parameter int SEL_W    = 2,
   parameter int BUS_W    = 32,
   localparam int SEL_BITS = PINS * SEL_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  gpm_addr_e           wr_addr,
   input  logic [BUS_W-1:0]    wdata,
   output logic [PINS-1:0]     out_q,
   output logic [PINS-1:0]     dir_q,
   output logic [PINS-1:0]     ien_q,
   output logic [PINS-1:0]     fen_q,
   output logic [SEL_BITS-1:0] sel_q
);

   logic [PINS-1:0] mask;
   assign mask = wdata[PINS-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= '0;
         dir_q <= '0;
         ien_q <= '0;
         fen_q <= '0;
         sel_q <= '0;
      end else if (wr_en) begin
         unique case (wr_addr)
            GPM_PIN_DATA: out_q <= mask;
            GPM_OUT_SET:  out_q <= out_q | mask;
            GPM_OUT_CLR:  out_q <= out_q & ~mask;
            GPM_DIR_SET: begin
               dir_q <= dir_q | mask;
               ien_q <= ien_q & ~mask;
            end
            GPM_DIR_CLR: begin
               dir_q <= dir_q & ~mask;
               ien_q <= ien_q | mask;
            end
            GPM_IN_EN:    ien_q <= mask;
            GPM_FN_EN:    fen_q <= mask;
            GPM_FN_SEL:   sel_q <= wdata[SEL_BITS-1:0];
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/gpm_pinmux.sv
module gpm_pinmux #(
   parameter int PINS  = 16,
   parameter int FUNCS = 4,
   parameter int SEL_W = 2,
   localparam int SEL_BITS = PINS * SEL_W,
   localparam int FN_BITS  = PINS * FUNCS
) (
   input  logic [PINS-1:0]     out_q,
   input  logic [PINS-1:0]     dir_q,
   input  logic [PINS-1:0]     fen_q,
   input  logic [SEL_BITS-1:0] sel_q,
   input  logic [PINS-1:0]     sync_in,
   input  logic [FN_BITS-1:0]  fn_out,
   input  logic [FN_BITS-1:0]  fn_oe,
   output logic [PINS-1:0]     pad_out,
   output logic [PINS-1:0]     pad_oe,
   output logic [FN_BITS-1:0]  fn_in
);

   for (genvar n = 0; n < PINS; n++) begin : g_pin
      logic [SEL_W-1:0] sel;
      logic [FUNCS-1:0] fo;
      logic [FUNCS-1:0] fe;

      assign sel = sel_q[n*SEL_W +: SEL_W];

      for (genvar f = 0; f < FUNCS; f++) begin : g_fn
         assign fo[f] = fn_out[f*PINS + n];
         assign fe[f] = fn_oe[f*PINS + n];
         assign fn_in[f*PINS + n] = fen_q[n] && (sel == SEL_W'(f)) && sync_in[n];
      end

      assign pad_out[n] = fen_q[n] ? fo[sel] : out_q[n];
      assign pad_oe[n]  = fen_q[n] ? fe[sel] : dir_q[n];
   end

endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
   import gpm_pkg::*;
#(
   parameter int NUM_PINS    = 16,
   parameter int NUM_FUNCS   = 4,
   parameter int BUS_W       = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           bus_wr,
   input  logic [GPM_ADDR_W-1:0]          bus_addr,
   input  logic [BUS_W-1:0]               bus_wdata,
   output logic [BUS_W-1:0]               bus_rdata,
   output logic [NUM_PINS-1:0]            pad_out,
   output logic [NUM_PINS-1:0]            pad_oe,
   input  logic [NUM_PINS-1:0]            pad_in,
   input  logic [NUM_FUNCS*NUM_PINS-1:0]  fn_out,
   input  logic [NUM_FUNCS*NUM_PINS-1:0]  fn_oe,
   output logic [NUM_FUNCS*NUM_PINS-1:0]  fn_in
);

   localparam int SEL_W    = (NUM_FUNCS > 1) ? $clog2(NUM_FUNCS) : 1;
   localparam int SEL_BITS = NUM_PINS * SEL_W;

   if ((1 << SEL_W) != NUM_FUNCS) begin : g_bad_funcs
      $error("NUM_FUNCS must be a power of two, at least 2");
   end
   if (SEL_BITS > BUS_W || NUM_PINS > BUS_W) begin : g_bad_bus
      $error("BUS_W too narrow for the selector register");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   gpm_addr_e            addr_e;
   logic [NUM_PINS-1:0]  out_q, dir_q, ien_q, fen_q, sync_in, pin_state, gpio_drv;
   logic [SEL_BITS-1:0]  sel_q;

   assign addr_e = gpm_addr_e'(bus_addr);

   gpm_regs #(.PINS(NUM_PINS), .SEL_W(SEL_W), .BUS_W(BUS_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bus_wr),
      .wr_addr (addr_e),
      .wdata   (bus_wdata),
      .out_q   (out_q),
      .dir_q   (dir_q),
      .ien_q   (ien_q),
      .fen_q   (fen_q),
      .sel_q   (sel_q)
   );

   gpm_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (sync_in)
   );

   gpm_pinmux #(.PINS(NUM_PINS), .FUNCS(NUM_FUNCS), .SEL_W(SEL_W)) u_mux (
      .out_q   (out_q),
      .dir_q   (dir_q),
      .fen_q   (fen_q),
      .sel_q   (sel_q),
      .sync_in (sync_in),
      .fn_out  (fn_out),
      .fn_oe   (fn_oe),
      .pad_out (pad_out),
      .pad_oe  (pad_oe),
      .fn_in   (fn_in)
   );

   assign gpio_drv  = ~fen_q & dir_q;
   assign pin_state = (gpio_drv & out_q) | (~gpio_drv & sync_in & ien_q);

   always_comb begin
      bus_rdata = '0;
      unique case (addr_e)
         GPM_PIN_DATA:             bus_rdata[NUM_PINS-1:0] = pin_state;
         GPM_OUT_SET, GPM_OUT_CLR: bus_rdata[NUM_PINS-1:0] = out_q;
         GPM_DIR_SET, GPM_DIR_CLR: bus_rdata[NUM_PINS-1:0] = dir_q;
         GPM_IN_EN:                bus_rdata[NUM_PINS-1:0] = ien_q;
         GPM_FN_EN:                bus_rdata[NUM_PINS-1:0] = fen_q;
         GPM_FN_SEL:               bus_rdata[SEL_BITS-1:0] = sel_q;
         default: ;
      endcase
   end

endmodule

// File: rtl/gpm_checker.sv
module gpm_checker #(
   parameter int PINS   = 16,
   parameter int FUNCS  = 4,
   parameter int BUS_W  = 32,
   parameter int STAGES = 2
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  bus_wr,
   input logic [2:0]            bus_addr,
   input logic [BUS_W-1:0]      bus_wdata,
   input logic [BUS_W-1:0]      bus_rdata,
   input logic [PINS-1:0]       pad_in,
   input logic [PINS-1:0]       out_q,
   input logic [PINS-1:0]       dir_q,
   input logic [PINS-1:0]       ien_q,
   input logic [PINS-1:0]       fen_q,
   input logic [FUNCS*PINS-1:0] fn_in
);

   logic [1:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   // R2: plain data write replaces the latch
   a_r2_data_replace: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 3'd0) |=> (out_q == $past(bus_wdata[PINS-1:0])));

   // R3: set alias
   a_r3_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 3'd1) |=> (out_q == ($past(out_q) | $past(bus_wdata[PINS-1:0]))));

   // R3: clear alias
   a_r3_clr_alias: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 3'd2) |=> (out_q == ($past(out_q) & ~$past(bus_wdata[PINS-1:0]))));

   // R5: making a pin an output drops its input enable
   a_r5_dirset_ien: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 3'd3) |=> ((ien_q & $past(bus_wdata[PINS-1:0])) == '0));

   // R5: making a pin an input raises its input enable
   a_r5_dirclr_ien: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 3'd4) |=> ((ien_q & $past(bus_wdata[PINS-1:0])) == $past(bus_wdata[PINS-1:0])));

   // R8: two-edge input latency, all pins enabled general-purpose inputs
   if (STAGES == 2) begin : g_lat
      a_r8_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
         (since_rst >= 2'd2 && bus_addr == 3'd0 && fen_q == '0 && dir_q == '0 && ien_q == '1)
            |-> (bus_rdata[PINS-1:0] == $past(pad_in, 2)));
   end

   // R10: a pin reaches at most one peripheral, and none when not lent
   for (genvar n = 0; n < PINS; n++) begin : g_route
      logic [FUNCS-1:0] seen;
      for (genvar f = 0; f < FUNCS; f++) begin : g_f
         assign seen[f] = fn_in[f*PINS + n];
      end
      a_r10_single_route: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(seen));
      a_r10_gpio_no_route: assert property (@(posedge clk) disable iff (!rst_n)
         !fen_q[n] |-> (seen == '0));
   end

endmodule

bind gpio_mux_port gpm_checker #(
   .PINS(NUM_PINS), .FUNCS(NUM_FUNCS), .BUS_W(BUS_W), .STAGES(SYNC_STAGES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pad_in    (pad_in),
   .out_q     (out_q),
   .dir_q     (dir_q),
   .ien_q     (ien_q),
   .fen_q     (fen_q),
   .fn_in     (fn_in)
);

// File: tb/gpio_mux_port_bench.sv
`timescale 1ns/1ps
module gpio_mux_port_bench;

   localparam int P = 16;
   localparam int F = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [2:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [P-1:0]  pad_out, pad_oe;
   logic [P-1:0]  pad_in = '0;
   logic [F*P-1:0] fn_out = '0, fn_oe = '0;
   logic [F*P-1:0] fn_in;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   gpio_mux_port u_gpio_mux_port (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_out(pad_out),
      .pad_oe(pad_oe), .pad_in(pad_in), .fn_out(fn_out), .fn_oe(fn_oe),
      .fn_in(fn_in)
   );

   // reference model state
   bit [P-1:0] m_out, m_dir, m_ien, m_fen, m_s1, m_s2;
   bit [31:0]  m_sel;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_out = '0; m_dir = '0; m_ien = '0; m_fen = '0; m_sel = '0;
         m_s1 = '0; m_s2 = '0;
      end else begin
         m_s2 = m_s1;
         m_s1 = pad_in;
         if (bus_wr) begin
            case (bus_addr)
               3'd0: m_out = bus_wdata[15:0];
               3'd1: for (int n = 0; n < P; n++) if (bus_wdata[n]) m_out[n] = 1'b1;
               3'd2: for (int n = 0; n < P; n++) if (bus_wdata[n]) m_out[n] = 1'b0;
               3'd3: for (int n = 0; n < P; n++) if (bus_wdata[n]) begin m_dir[n] = 1'b1; m_ien[n] = 1'b0; end
               3'd4: for (int n = 0; n < P; n++) if (bus_wdata[n]) begin m_dir[n] = 1'b0; m_ien[n] = 1'b1; end
               3'd5: m_ien = bus_wdata[15:0];
               3'd6: m_fen = bus_wdata[15:0];
               default: m_sel = bus_wdata;
            endcase
         end
      end
   end

   function automatic int sel_of(int n);
      return int'(m_sel[2*n +: 2]);
   endfunction

   function automatic bit [31:0] exp_rdata(bit [2:0] a);
      bit [31:0] r = '0;
      case (a)
         3'd0: for (int n = 0; n < P; n++)
                  r[n] = (!m_fen[n] && m_dir[n]) ? m_out[n] : (m_s2[n] & m_ien[n]);
         3'd1, 3'd2: r[15:0] = m_out;
         3'd3, 3'd4: r[15:0] = m_dir;
         3'd5: r[15:0] = m_ien;
         3'd6: r[15:0] = m_fen;
         default: r = m_sel;
      endcase
      return r;
   endfunction

   function automatic bit [P-1:0] exp_pad(bit oe);
      bit [P-1:0] r;
      for (int n = 0; n < P; n++) begin
         if (m_fen[n]) r[n] = oe ? fn_oe[sel_of(n)*P + n] : fn_out[sel_of(n)*P + n];
         else          r[n] = oe ? m_dir[n] : m_out[n];
      end
      return r;
   endfunction

   function automatic bit [F*P-1:0] exp_fn_in();
      bit [F*P-1:0] r = '0;
      for (int n = 0; n < P; n++)
         if (m_fen[n]) r[sel_of(n)*P + n] = m_s2[n];
      return r;
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk(bus_addr == 3'd0 ? "R7 pin state read" : "R11 register readback",
          64'(bus_rdata), 64'(exp_rdata(bus_addr)));
      chk("R4/R9 pad_out", 64'(pad_out), 64'(exp_pad(1'b0)));
      chk("R4/R9 pad_oe",  64'(pad_oe),  64'(exp_pad(1'b1)));
      chk("R10 fn_in", fn_in, exp_fn_in());
   endtask

   task automatic cyc(input bit w, input bit [2:0] a, input bit [31:0] d);
      bus_wr = w; bus_addr = a; bus_wdata = d;
      #1;
      compare_all();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic rd(input bit [2:0] a, input bit [31:0] exp, input string req);
      bus_wr = 1'b0; bus_addr = a; bus_wdata = '0;
      #1;
      chk(req, 64'(bus_rdata), 64'(exp));
      compare_all();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL R1 watchdog: actual %0d cycles expected fewer", 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int a = 0; a < 8; a++) rd(3'(a), 32'h0, "R1 reset read");
      chk("R1 reset pad_oe", 64'(pad_oe), 64'h0);
      chk("R1 reset pad_out", 64'(pad_out), 64'h0);

      // R2, R3 latch writes
      cyc(1, 3'd0, 32'h0000_A5A5);
      rd(3'd1, 32'h0000_A5A5, "R2 latch replace");
      cyc(1, 3'd1, 32'h0000_000F);
      rd(3'd2, 32'h0000_A5AF, "R3 set alias");
      cyc(1, 3'd2, 32'h0000_0101);
      rd(3'd1, 32'h0000_A4AE, "R3 clear alias");

      // R4, R5 direction and input enable coupling
      cyc(1, 3'd4, 32'h0000_FF00);
      rd(3'd5, 32'h0000_FF00, "R5 dir clear sets ien");
      cyc(1, 3'd5, 32'h0000_FFFF);
      cyc(1, 3'd3, 32'h0000_0F00);
      rd(3'd5, 32'h0000_F0FF, "R5 dir set clears ien");
      rd(3'd3, 32'h0000_0F00, "R4 dir readback");
      chk("R4 gpio pad_oe", 64'(pad_oe), 64'h0F00);
      chk("R4 gpio pad_out", 64'(pad_out), 64'hA4AE);

      // R8 two-edge latency, R7 mixed read
      pad_in = 16'h1234;
      rd(3'd0, 32'h0000_0400, "R8 not yet visible");
      rd(3'd0, 32'h0000_0400, "R8 one edge");
      rd(3'd0, 32'h0000_1434, "R7 pin state after two edges");

      // R6 input enable gating
      cyc(1, 3'd5, 32'h0000_0000);
      rd(3'd0, 32'h0000_0400, "R6 gated inputs read zero");

      // R9 peripheral ownership
      fn_out = {16'h0000, 16'hFFFF, 16'h0000, 16'h0000};
      fn_oe  = {16'hFFFF, 16'h0F0F, 16'hFFFF, 16'hFFFF};
      cyc(1, 3'd7, 32'hAAAA_AAAA);
      cyc(1, 3'd6, 32'h0000_00FF);
      chk("R9 peripheral pad_out", 64'(pad_out), 64'hA4FF);
      chk("R9 peripheral pad_oe", 64'(pad_oe), 64'h0F0F);
      cyc(1, 3'd3, 32'h0000_00FF);
      chk("R9 direction ignored", 64'(pad_oe), 64'h0F0F);
      chk("R10 routed input", fn_in, 64'h0000_0034_0000_0000);
      rd(3'd6, 32'h0000_00FF, "R11 fen readback");
      rd(3'd7, 32'hAAAA_AAAA, "R11 sel readback");

      // random phase: writes collide with pad and peripheral changes
      for (int i = 0; i < 4000; i++) begin
         pad_in = 16'($urandom);
         fn_out = {$urandom, $urandom};
         fn_oe  = {$urandom, $urandom};
         cyc(($urandom % 3) != 0, 3'($urandom), $urandom);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule